// File: doc/BRIEF.md
# Branch Trace Message Encoder

This block turns one taken-branch event into a trace message made of two special bus cycles. The first cycle describes where the branch left from and the second describes where it landed. On the branch side there is a valid strobe that carries these values:

- the source and target code-segment selectors
- the source and target instruction pointers
- the operating mode that applies at the target
- the default operand size that applies at the target

On acceptance the block latches the whole event. It then presents the source cycle and afterwards the target cycle on a request/acknowledge output. Each cycle shows a 32-bit address-style field word and a data word.

The output is a valid/ready stream: `msg_req` is valid and `msg_ack` is ready. A cycle completes on a clock edge where both are high. Until that edge the word and the data are held unchanged. The branch input is also a valid/ready stream, with `br_ready` as its ready. The input side does not stall, however. A strobe offered while a message is still in flight is lost, and each lost strobe adds one to a saturating drop counter. Branch decoding, byte-enable generation and the rest of the bus protocol belong to the surrounding logic.

Top module: `btm_encoder`

## Requirements
- R1: While reset is applied and directly after it, `msg_req`=0, `busy`=0, `br_ready`=1 and `drop_count`=0.
- R2: A strobe on `br_valid` sampled while idle is accepted. From the next cycle `busy`=1 and `msg_req`=1, and the first cycle shown is always the source cycle.
- R3: Source cycle: address bit 31 = 0, bits 30..28 = 0, bits 19..4 = source selector, data = source instruction pointer.
- R4: Target cycle: address bit 31 = 1, bits 19..4 = target selector, data = target instruction pointer.
- R5: Target cycle, bits 30..29 from `br_tgt_mode`: input 00 (real) gives 00, input 01 (protected) gives 10, inputs 10 and 11 (virtual-8086) give 11. The code 01 never appears.
- R6: Target cycle, bit 28 = `br_tgt_op32` (1 = 32-bit default operand size, 0 = 16-bit).
- R7: In both cycles, bits 27..20 and bits 3..0 are 0.
- R8: While `msg_req`=1 and `msg_ack`=0, the next cycle still has `msg_req`=1 with `msg_addr` and `msg_data` unchanged.
- R9: If `msg_ack` is sampled in the source cycle, the target cycle follows on the next cycle. If it is sampled in the target cycle, `msg_req` and `busy` fall on the next cycle.
- R10: Each cycle in which `br_valid` is sampled while busy adds 1 to `drop_count`, which saturates at all-ones. The dropped strobe leaves the message in flight unchanged.
- R11: `br_ready` is the inverse of `busy` at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| br_valid | input | 1 | Branch event strobe |
| br_ready | output | 1 | High when a strobe would be accepted |
| br_src_sel | input | 16 | Source code-segment selector |
| br_src_ip | input | DATA_W | Source instruction pointer |
| br_tgt_sel | input | 16 | Target code-segment selector |
| br_tgt_ip | input | DATA_W | Target instruction pointer |
| br_tgt_mode | input | 2 | Target mode: 00 real, 01 protected, 1x virtual-8086 |
| br_tgt_op32 | input | 1 | Target default operand size is 32-bit |
| msg_req | output | 1 | Special-cycle request (valid) |
| msg_ack | input | 1 | Cycle acknowledge (ready) |
| msg_addr | output | 32 | Address-style field word |
| msg_data | output | DATA_W | Data word |
| busy | output | 1 | Message in flight |
| drop_count | output | CNT_W | Saturating count of dropped strobes |

## Verification
Every result appears exactly one clock after the edge that causes it:

- the source cycle follows acceptance by one clock;
- the target cycle follows the first acknowledge by one clock;
- the fall of `busy` follows the second acknowledge by one clock;
- each increment of the drop counter follows its dropped strobe by one clock.

The bench changes inputs at the falling edge and checks outputs at the next falling edge. It therefore samples half a period after the single register stage that produces each result. It sweeps every mode code, both operand sizes and stalls of zero to two cycles, and it keeps a running expected drop count that includes the saturation point.

// File: rtl/btm_pkg.sv
package btm_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_SRC  = 2'd1,
    PH_TGT  = 2'd2
  } phase_e;

  localparam int ADDR_W   = 32;
  localparam int SEL_W    = 16;
  localparam int TAG_BIT  = 31;
  localparam int MODE_LO  = 29;
  localparam int OPS_BIT  = 28;
  localparam int SEL_LO   = 4;

  // input mode -> field code (never 01)
  function automatic logic [1:0] mode_code(input logic [1:0] m);
    case (m)
      2'b00:   return 2'b00;
      2'b01:   return 2'b10;
      default: return 2'b11;
    endcase
  endfunction
endpackage

// File: rtl/btm_capture.sv
module btm_capture #(
  parameter int DATA_W = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      load,
  input  logic [btm_pkg::SEL_W-1:0] in_src_sel,
  input  logic [DATA_W-1:0]         in_src_ip,
  input  logic [btm_pkg::SEL_W-1:0] in_tgt_sel,
  input  logic [DATA_W-1:0]         in_tgt_ip,
  input  logic [1:0]                in_mode,
  input  logic                      in_op32,
  output logic [btm_pkg::SEL_W-1:0] src_sel,
  output logic [DATA_W-1:0]         src_ip,
  output logic [btm_pkg::SEL_W-1:0] tgt_sel,
  output logic [DATA_W-1:0]         tgt_ip,
  output logic [1:0]                mode,
  output logic                      op32
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_sel <= '0;
      src_ip  <= '0;
      tgt_sel <= '0;
      tgt_ip  <= '0;
      mode    <= '0;
      op32    <= 1'b0;
    end else if (load) begin
      src_sel <= in_src_sel;
      src_ip  <= in_src_ip;
      tgt_sel <= in_tgt_sel;
      tgt_ip  <= in_tgt_ip;
      mode    <= in_mode;
      op32    <= in_op32;
    end
  end

  // R10: the record never changes while it is not being loaded
  p_hold_record_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(src_ip) && $stable(tgt_ip) && $stable(src_sel) && $stable(tgt_sel));
endmodule

// File: rtl/btm_seq.sv
module btm_seq (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            br_valid,
  input  logic            ack,
  output btm_pkg::phase_e phase,
  output logic            load,
  output logic            drop,
  output logic            busy
);
  import btm_pkg::*;

  phase_e nxt;

  assign busy = (phase != PH_IDLE);
  assign load = br_valid && !busy;
  assign drop = br_valid && busy;

  always_comb begin
    nxt = phase;
    case (phase)
      PH_IDLE: if (br_valid) nxt = PH_SRC;
      PH_SRC:  if (ack)      nxt = PH_TGT;
      PH_TGT:  if (ack)      nxt = PH_IDLE;
      default:               nxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= PH_IDLE;
    else        phase <= nxt;
  end

  p_accept_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> phase == PH_SRC);
  p_src_to_tgt_r9: assert property (@(posedge clk) disable iff (!rst_n)
    phase == PH_SRC && ack |=> phase == PH_TGT);
  p_tgt_to_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    phase == PH_TGT && ack |=> phase == PH_IDLE);
  p_wait_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !ack |=> $stable(phase));
endmodule

// File: rtl/btm_format.sv
module btm_format #(
  parameter int DATA_W = 32
) (
  input  btm_pkg::phase_e                 phase,
  input  logic [btm_pkg::SEL_W-1:0]       src_sel,
  input  logic [DATA_W-1:0]               src_ip,
  input  logic [btm_pkg::SEL_W-1:0]       tgt_sel,
  input  logic [DATA_W-1:0]               tgt_ip,
  input  logic [1:0]                      mode,
  input  logic                            op32,
  output logic                            req,
  output logic [btm_pkg::ADDR_W-1:0]      addr,
  output logic [DATA_W-1:0]               data
);
  import btm_pkg::*;

  always_comb begin
    req  = 1'b0;
    addr = '0;
    data = '0;
    case (phase)
      PH_SRC: begin
        req                   = 1'b1;
        addr[SEL_LO +: SEL_W] = src_sel;
        data                  = src_ip;
      end
      PH_TGT: begin
        req                   = 1'b1;
        addr[TAG_BIT]         = 1'b1;
        addr[MODE_LO +: 2]    = mode_code(mode);
        addr[OPS_BIT]         = op32;
        addr[SEL_LO +: SEL_W] = tgt_sel;
        data                  = tgt_ip;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/btm_drop_cnt.sv
module btm_drop_cnt #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             drop,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        count <= '0;
    else if (drop && count != CNT_MAX) count <= count + 1'b1;
  end

  p_saturate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    count == CNT_MAX |=> count == CNT_MAX);
  p_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !drop |=> $stable(count));
endmodule

// File: rtl/btm_encoder.sv
module btm_encoder #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              br_valid,
  output logic              br_ready,
  input  logic [15:0]       br_src_sel,
  input  logic [DATA_W-1:0] br_src_ip,
  input  logic [15:0]       br_tgt_sel,
  input  logic [DATA_W-1:0] br_tgt_ip,
  input  logic [1:0]        br_tgt_mode,
  input  logic              br_tgt_op32,
  output logic              msg_req,
  input  logic              msg_ack,
  output logic [31:0]       msg_addr,
  output logic [DATA_W-1:0] msg_data,
  output logic              busy,
  output logic [CNT_W-1:0]  drop_count
);
  import btm_pkg::*;

  phase_e            phase;
  logic              load, drop;
  logic [SEL_W-1:0]  c_src_sel, c_tgt_sel;
  logic [DATA_W-1:0] c_src_ip, c_tgt_ip;
  logic [1:0]        c_mode;
  logic              c_op32;

  btm_seq u_seq (
    .clk(clk), .rst_n(rst_n), .br_valid(br_valid), .ack(msg_ack),
    .phase(phase), .load(load), .drop(drop), .busy(busy)
  );

  btm_capture #(.DATA_W(DATA_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .load(load),
    .in_src_sel(br_src_sel), .in_src_ip(br_src_ip),
    .in_tgt_sel(br_tgt_sel), .in_tgt_ip(br_tgt_ip),
    .in_mode(br_tgt_mode), .in_op32(br_tgt_op32),
    .src_sel(c_src_sel), .src_ip(c_src_ip),
    .tgt_sel(c_tgt_sel), .tgt_ip(c_tgt_ip),
    .mode(c_mode), .op32(c_op32)
  );

  btm_format #(.DATA_W(DATA_W)) u_fmt (
    .phase(phase), .src_sel(c_src_sel), .src_ip(c_src_ip),
    .tgt_sel(c_tgt_sel), .tgt_ip(c_tgt_ip), .mode(c_mode), .op32(c_op32),
    .req(msg_req), .addr(msg_addr), .data(msg_data)
  );

  btm_drop_cnt #(.CNT_W(CNT_W)) u_drop (
    .clk(clk), .rst_n(rst_n), .drop(drop), .count(drop_count)
  );

  assign br_ready = !busy;

  p_src_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(msg_req) |-> !msg_addr[TAG_BIT]);
  p_src_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    msg_req && !msg_addr[TAG_BIT] |-> msg_addr[30:28] == 3'b000);
  p_mode_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
    msg_req && msg_addr[TAG_BIT] |-> msg_addr[30:29] != 2'b01);
  p_zero_fields_r7: assert property (@(posedge clk) disable iff (!rst_n)
    msg_req |-> msg_addr[27:20] == 8'h00 && msg_addr[3:0] == 4'h0);
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    msg_req && !msg_ack |=> msg_req && $stable(msg_addr) && $stable(msg_data));
  p_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
    msg_req && msg_addr[TAG_BIT] && msg_ack |=> !busy && !msg_req);
  p_req_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    msg_req == busy);
endmodule

// File: tb/tb_btm_encoder.sv
module tb_btm_encoder;
  localparam int DATA_W = 32;
  localparam int CNT_W  = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic br_valid = 1'b0, br_ready, br_tgt_op32 = 1'b0;
  logic [15:0] br_src_sel = '0, br_tgt_sel = '0;
  logic [DATA_W-1:0] br_src_ip = '0, br_tgt_ip = '0;
  logic [1:0] br_tgt_mode = '0;
  logic msg_req, msg_ack = 1'b0, busy;
  logic [31:0] msg_addr;
  logic [DATA_W-1:0] msg_data;
  logic [CNT_W-1:0] drop_count;

  int checks = 0;
  int fails  = 0;
  int exp_cnt = 0;

  always #2.5 clk = ~clk;

  btm_encoder #(.DATA_W(DATA_W), .CNT_W(CNT_W)) dut (.*);

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_mode(input logic [1:0] m);
    return (m == 2'd0) ? 2'd0 : (m == 2'd1) ? 2'd2 : 2'd3;
  endfunction

  function automatic logic [31:0] src_word(input logic [15:0] s);
    return {1'b0, 3'b000, 8'h00, s, 4'h0};
  endfunction

  function automatic logic [31:0] tgt_word(input logic [1:0] m, input logic o, input logic [15:0] s);
    return {1'b1, exp_mode(m), o, 8'h00, s, 4'h0};
  endfunction

  task automatic set_branch(input int n, input logic [1:0] m, input logic o);
    br_src_sel  = 16'h1000 + 16'(n * 37);
    br_tgt_sel  = ~(16'h1000 + 16'(n * 37));
    br_src_ip   = 32'hA000_0000 + 32'(n * 1234567);
    br_tgt_ip   = (32'hA000_0000 + 32'(n * 1234567)) ^ 32'h5A5A_F00F;
    br_tgt_mode = m;
    br_tgt_op32 = o;
  endtask

  task automatic run_msg(input int n, input logic [1:0] m, input logic o, input int stall);
    logic [15:0] ss, ts;
    logic [31:0] si, ti;
    set_branch(n, m, o);
    ss = br_src_sel; ts = br_tgt_sel; si = br_src_ip; ti = br_tgt_ip;
    chk("R11 ready idle", br_ready, 1);
    br_valid = 1'b1;
    @(negedge clk);
    chk("R2 busy", busy, 1);
    chk("R2 req", msg_req, 1);
    chk("R11 ready busy", br_ready, 0);
    chk("R3 src addr", msg_addr, src_word(ss));
    chk("R3 src data", msg_data, si);
    for (int k = 0; k < stall; k++) begin
      set_branch(n + 500 + k, ~m, ~o);   // junk strobe, must be dropped
      br_valid = 1'b1;
      @(negedge clk);
      if (exp_cnt < 255) exp_cnt++;
      chk("R8 hold addr", msg_addr, src_word(ss));
      chk("R8 hold data", msg_data, si);
      chk("R10 drop count", drop_count, exp_cnt);
    end
    br_valid = 1'b0;
    msg_ack = 1'b1;
    @(negedge clk);
    chk("R9 tgt req", msg_req, 1);
    chk("R4 tgt addr R5 R6 R7", msg_addr, tgt_word(m, o, ts));
    chk("R4 tgt data", msg_data, ti);
    @(negedge clk);
    chk("R9 req low", msg_req, 0);
    chk("R9 busy low", busy, 0);
    msg_ack = 1'b0;
  endtask

  initial begin
    #100000;
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int n;
    @(negedge clk);
    chk("R1 req reset", msg_req, 0);
    chk("R1 busy reset", busy, 0);
    chk("R1 ready reset", br_ready, 1);
    chk("R1 count reset", drop_count, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 req after reset", msg_req, 0);
    n = 0;
    for (int m = 0; m < 4; m++)
      for (int o = 0; o < 2; o++)
        for (int s = 0; s < 3; s++) begin
          run_msg(n, 2'(m), 1'(o), s);
          n++;
        end
    // R10 saturation: long stall with continuous strobes
    run_msg(99, 2'd2, 1'b1, 300);
    chk("R10 saturated", drop_count, 255);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule